// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records when an external signal changes. A counter that runs outside the block feeds its value in. When the selected edge shows up on the pin, the block copies that counter value into a capture register. The capture also sets a sticky flag. An interrupt request is raised while that flag is set and the interrupt is enabled. Software, or a surrounding register block, clears the flag with a one-cycle strobe.

The raw pin is asynchronous, so it first passes through a two-stage synchronizer. After that it can be cleaned by an optional glitch filter. The filter accepts a new level only once four consecutive samples agree. A direction bit picks whether rising or falling transitions are timestamped.

When the surrounding timer uses the capture register as its period limit, the pin is cut off from the capture logic. Neither the register nor the flag can then be disturbed.

Top module: `edge_stamp_unit`

## Requirements
- R1: With `filt_en` high, the level seen by the edge detector changes only after four consecutive synchronized samples all hold the new value. A pulse that lasts three clock cycles or less produces no capture.
- R2: With `filt_en` low, a pin change applied before clock edge E0 stores the counter value present just before edge E2. With `filt_en` high, the stored value is the one present just before edge E6, which is four cycles later.
- R3: `rise_sel` = 0 selects falling edges (1 to 0) and `rise_sel` = 1 selects rising edges (0 to 1). The opposite edge causes no capture.
- R4: A capture copies the full `count_in` value into `cap_val`, which then holds it until the next capture.
- R5: A capture sets `cap_flag`. `cap_irq` is high exactly when `cap_flag` and `irq_en` are both high.
- R6: `cap_flag` stays set until a cycle with `flag_clr` high, after which it reads 0.
- R7: If a capture and `flag_clr` fall in the same cycle, `cap_flag` ends up set.
- R8: While `top_is_cap` is high, pin edges change neither `cap_val` nor `cap_flag`.
- R9: After a synchronous active-low reset, `cap_val` is 0, `cap_flag` and `cap_irq` are 0, and both the filtered level and the filter history read high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_raw | input | 1 | Asynchronous capture pin |
| count_in | input | 16 | Value of the free-running counter |
| filt_en | input | 1 | Enables the four-sample glitch filter |
| rise_sel | input | 1 | 1 selects rising edges, 0 selects falling edges |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle strobe that clears the flag |
| top_is_cap | input | 1 | Capture register serves as counter limit; capture disabled |
| cap_val | output | 16 | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
A corrupted synchronizer or filter stage shows up as a timestamp that is off by whole cycles. It can also show up as a capture on a glitch that should have been rejected. Either way it is visible at `cap_val` within six cycles of the pin change, because every pin change leaves a distinct timestamp.

A stale previous-level register gives a spurious capture, or a missed one, on the very next change of the filtered level. A broken flag path appears at `cap_flag` and `cap_irq` on the cycle after the capture or clear. That includes the case where a capture and a clear collide in the same cycle.

// File: rtl/esu_pkg.sv
// Package: shared types and constants for the edge timestamp capture unit.
// Assumes: nothing beyond IEEE 1800-2017.
package esu_pkg;
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_dir_e;

    localparam int unsigned ESU_MIN_STAGES = 2;
endpackage

// File: rtl/esu_sync.sv
// Module: multi-stage synchronizer that brings an asynchronous level into clk.
// Assumes: STAGES >= 2; every stage resets to RST_VAL so no edge appears at reset.
module esu_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/esu_filter.sv
// Module: glitch filter. The output takes a new level only when TAPS consecutive
// samples (the live one plus TAPS-1 stored ones) agree. Bypassed when en is low.
// Assumes: TAPS >= 2; din is already synchronous to clk.
module esu_filter #(
    parameter int unsigned TAPS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);
    localparam int unsigned HIST_W = TAPS - 1;

    logic [HIST_W-1:0] hist_q;
    logic [TAPS-1:0]   window;
    logic              filt_q;

    assign window = {hist_q, din};

    // Keep the last TAPS-1 samples of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= {HIST_W{1'b1}};
        else        hist_q <= {hist_q[HIST_W-2:0], din};
    end

    // Update the filtered level once the whole window agrees.
    always_ff @(posedge clk) begin
        if (!rst_n)           filt_q <= 1'b1;
        else if (&window)     filt_q <= 1'b1;
        else if (!(|window))  filt_q <= 1'b0;
    end

    assign dout = en ? filt_q : din;

    // The filtered level only moves to a value the input and the history both carried.
    p_filter_agree_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> (($past(din) == filt_q) && ($past(hist_q[HIST_W-1]) == filt_q)));
endmodule

// File: rtl/esu_capture.sv
// Module: edge detector, timestamp register and sticky flag with interrupt.
// Assumes: level is synchronous to clk; the previous-level register resets high,
// which matches the reset level of the filter, so reset creates no edge.
module esu_capture #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  logic             rise_sel,
    input  logic             top_sel,
    input  logic [CNT_W-1:0] count_in,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_q,
    output logic             flag_q,
    output logic             irq
);
    import esu_pkg::*;

    edge_dir_e dir;
    logic      prev_q;
    logic      rose, fell, evt;

    assign dir  = edge_dir_e'(rise_sel);
    assign rose = level & ~prev_q;
    assign fell = ~level & prev_q;
    assign evt  = !top_sel && ((dir == EDGE_RISE) ? rose : fell);

    // Remember the level of the last cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= level;
    end

    // Latch the counter on a qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   cap_q <= '0;
        else if (evt) cap_q <= count_in;
    end

    // Sticky flag; a capture takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (evt)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign irq = flag_q & irq_en;

    p_edge_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (level == rise_sel) && (prev_q != rise_sel));
    p_cap_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (cap_q == $past(count_in)));
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag_q);
    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
    p_cap_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && flag_clr) |=> flag_q);
    p_top_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (top_sel && !flag_q) |=> ($stable(cap_q) && !flag_q));
endmodule

// File: rtl/edge_stamp_unit.sv
// Module: top of the edge timestamp capture unit. It chains the synchronizer,
// the optional glitch filter and the capture stage.
// Assumes: count_in is synchronous to clk; control inputs are quasi-static.
module edge_stamp_unit #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_TAPS   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_raw,
    input  logic [CNT_W-1:0] count_in,
    input  logic             filt_en,
    input  logic             rise_sel,
    input  logic             irq_en,
    input  logic             flag_clr,
    input  logic             top_is_cap,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             cap_irq
);
    logic pin_sync;
    logic pin_level;

    esu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_raw),
        .dout (pin_sync)
    );

    esu_filter #(.TAPS(FILT_TAPS)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (filt_en),
        .din  (pin_sync),
        .dout (pin_level)
    );

    esu_capture #(.CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (pin_level),
        .rise_sel(rise_sel),
        .top_sel (top_is_cap),
        .count_in(count_in),
        .irq_en  (irq_en),
        .flag_clr(flag_clr),
        .cap_q   (cap_val),
        .flag_q  (cap_flag),
        .irq     (cap_irq)
    );
endmodule

// File: tb/sim_edge_stamp_unit.sv
module sim_edge_stamp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_raw = 1'b1;
    logic [15:0] cnt = 16'd0;
    logic        filt_en = 1'b0, rise_sel = 1'b0, irq_en = 1'b0;
    logic        flag_clr = 1'b0, top_is_cap = 1'b0;
    logic [15:0] cap_val;
    logic        cap_flag, cap_irq;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] last_cap = 16'd0;
    bit          done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 16'd1;

    edge_stamp_unit u0 (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .count_in(cnt),
        .filt_en(filt_en), .rise_sel(rise_sel), .irq_en(irq_en),
        .flag_clr(flag_clr), .top_is_cap(top_is_cap),
        .cap_val(cap_val), .cap_flag(cap_flag), .cap_irq(cap_irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: change the pin at a falling clock edge; queue the expected timestamp.
    task automatic drive_pin(input logic v, input bit expect_cap, input int lat, input string tag);
        @(negedge clk);
        pin_raw = v;
        if (expect_cap) begin
            exp_q.push_back(cnt + 16'(lat));
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Monitor: each change of cap_val is one capture; compare with the queue.
    always @(negedge clk) begin
        if (rst_n && (cap_val !== last_cap)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R8 unexpected capture", 32'(cap_val), 32'(last_cap));
            end else begin
                string t;
                logic [15:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(cap_val == e, t, 32'(cap_val), 32'(e));
            end
            last_cap = cap_val;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        logic [15:0] saved;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(cap_val == 16'd0, "R9 cap_val", 32'(cap_val), 0);
        check(cap_flag == 1'b0, "R9 cap_flag", 32'(cap_flag), 0);
        check(cap_irq == 1'b0, "R9 cap_irq", 32'(cap_irq), 0);
        idle(6);

        // R3 R4 R2: falling edge, bypassed filter, latency 2
        drive_pin(1'b0, 1'b1, 2, "R2/R4 bypass falling timestamp");
        idle(5);
        check(cap_flag == 1'b1, "R5 flag after capture", 32'(cap_flag), 1);
        check(cap_irq == 1'b0, "R5 irq masked", 32'(cap_irq), 0);
        irq_en = 1'b1;
        @(negedge clk);
        check(cap_irq == 1'b1, "R5 irq enabled", 32'(cap_irq), 1);
        idle(5);
        check(cap_flag == 1'b1, "R6 flag held", 32'(cap_flag), 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(cap_flag == 1'b0, "R6 flag cleared", 32'(cap_flag), 0);
        check(cap_irq == 1'b0, "R5 irq follows flag", 32'(cap_irq), 0);

        // R3: rising edge ignored while falling is selected
        drive_pin(1'b1, 1'b0, 0, "");
        idle(6);
        check(cap_flag == 1'b0, "R3 opposite edge ignored", 32'(cap_flag), 0);

        // R3: rising select, falling ignored then rising captured
        rise_sel = 1'b1;
        drive_pin(1'b0, 1'b0, 0, "");
        idle(6);
        check(cap_flag == 1'b0, "R3 falling ignored under rise select", 32'(cap_flag), 0);
        drive_pin(1'b1, 1'b1, 2, "R3 rising timestamp");
        idle(5);
        check(cap_flag == 1'b1, "R3 rising sets flag", 32'(cap_flag), 1);

        // R7: clear and capture in the same cycle
        rise_sel = 1'b0;
        drive_pin(1'b0, 1'b1, 2, "R7 collision timestamp");
        @(negedge clk);
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(cap_flag == 1'b1, "R7 capture beats clear", 32'(cap_flag), 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        idle(4);

        // R2: filtered rising edge, latency 6
        filt_en = 1'b1;
        rise_sel = 1'b1;
        idle(4);
        drive_pin(1'b1, 1'b1, 6, "R2 filtered timestamp");
        idle(10);

        // R1: three-cycle glitch rejected
        rise_sel = 1'b0;
        saved = cap_val;
        drive_pin(1'b0, 1'b0, 0, "");
        idle(2);
        drive_pin(1'b1, 1'b0, 0, "");
        idle(12);
        check(cap_val == saved, "R1 short glitch rejected", 32'(cap_val), 32'(saved));

        // R1: four-cycle pulse accepted
        drive_pin(1'b0, 1'b1, 6, "R1 four-sample pulse timestamp");
        idle(3);
        drive_pin(1'b1, 1'b0, 0, "");
        idle(12);

        // R8: capture register used as limit
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        filt_en = 1'b0;
        top_is_cap = 1'b1;
        saved = cap_val;
        drive_pin(1'b0, 1'b0, 0, "");
        idle(5);
        drive_pin(1'b1, 1'b0, 0, "");
        idle(5);
        check(cap_val == saved, "R8 cap_val frozen", 32'(cap_val), 32'(saved));
        check(cap_flag == 1'b0, "R8 flag untouched", 32'(cap_flag), 0);
        top_is_cap = 1'b0;
        idle(2);
        drive_pin(1'b0, 1'b1, 2, "R8 reconnect timestamp");
        idle(6);

        check(exp_q.size() == 0, "R4 all expected captures seen", 32'(exp_q.size()), 0);
        summary();
    end
endmodule